// File: doc/BRIEF.md
# Odd-Parity Single-Error-Correcting Codec for 4-Bit Words

This block protects a 4-bit data word with three parity bits so that any single flipped bit in the resulting 7-bit codeword can be found and repaired. It has two independent paths that run side by side. The encode path turns a data nibble into a codeword. The correct path takes a received codeword, recomputes its three checks and builds a 3-bit syndrome from them. It then inverts the single bit that the syndrome points at and returns the repaired data nibble, the syndrome and an error flag.

The parity is odd. Each parity bit is chosen so that its group, with the parity bit included, holds an odd number of ones. Each check is taken as the complement of the XOR over its group. A clean codeword therefore yields a zero syndrome. Both paths are combinational. A parameter places an output register after each path, and that register is on by default, so results appear one clock after the inputs are presented.

Top module: `ham74_odd_codec`

## Requirements
- R1: Data bits are named D1..D4 and sit on `enc_data_in[0]`..`enc_data_in[3]`. The codeword bits, listed from `enc_code_out[0]` up to `enc_code_out[6]`, are P1, P2, D1, P3, D2, D3, D4. The parity bits are P1 = ~(D1^D2^D3), P2 = ~(D1^D3^D4) and P3 = ~(D2^D3^D4).
- R2: In every encoded codeword, each group {P1,D1,D2,D3}, {P2,D1,D3,D4} and {P3,D2,D3,D4} contains an odd number of ones.
- R3: `dec_syndrome[0]`, `[1]` and `[2]` are the XNOR over the received P1, P2 and P3 groups of R2, in that order. A valid codeword gives syndrome 3'b000.
- R4: With no error, or with a single flipped data bit, `dec_data_out` equals the original data nibble.
- R5: A single flipped parity bit gives syndrome 1 (P1), 2 (P2) or 4 (P3), and `dec_data_out` equals the received data bits unchanged.
- R6: `dec_error` is 1 exactly when `dec_syndrome` is nonzero.
- R7: A single flip at codeword index 0..6 gives syndrome 1, 2, 3, 4, 5, 7 and 6 respectively. Syndromes 6 and 7 therefore map to D4 and D3.
- R8: With the output register enabled (the default), every output reflects the inputs present at the previous rising clock edge. A synchronous active-high reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output registers |
| rst | input | 1 | Synchronous active-high reset |
| enc_data_in | input | 4 | Data nibble to encode, D1 on bit 0 |
| enc_code_out | output | 7 | Encoded codeword, P1 on bit 0 |
| dec_code_in | input | 7 | Received codeword to check and repair |
| dec_data_out | output | 4 | Repaired data nibble |
| dec_syndrome | output | 3 | Check result, zero when clean |
| dec_error | output | 1 | High when a single-bit error was located |

## Verification
With the default output register, every result is due exactly one rising edge after its inputs are applied. The bench changes the inputs on a falling edge and samples all outputs on the next falling edge, which is one register stage later. It also samples once directly after a change to confirm that the outputs still hold the previous result until that edge. Every one of the 16 nibbles is tried with each of the 7 single flips and with no flip. Seeded random vectors are added on top, and each case is compared against the encoder, syndrome table and data values the bench computes itself.

// File: rtl/ham74_pkg.sv
package ham74_pkg;

    localparam int DATA_W = 4;
    localparam int CODE_W = 7;
    localparam int SYN_W  = 3;

    // codeword index of each field (behaviour depends on this order)
    localparam int IX_P1 = 0;
    localparam int IX_P2 = 1;
    localparam int IX_D1 = 2;
    localparam int IX_P3 = 3;
    localparam int IX_D2 = 4;
    localparam int IX_D3 = 5;
    localparam int IX_D4 = 6;

    typedef logic [DATA_W-1:0] nib_t;
    typedef logic [CODE_W-1:0] cw_t;
    typedef logic [SYN_W-1:0]  syn_t;

    typedef struct packed {
        nib_t data;
        syn_t syn;
        logic err;
    } chk_res_t;

    function automatic cw_t ham_encode(input nib_t d);
        cw_t c;
        c[IX_D1] = d[0];
        c[IX_D2] = d[1];
        c[IX_D3] = d[2];
        c[IX_D4] = d[3];
        c[IX_P1] = ~(d[0] ^ d[1] ^ d[2]);
        c[IX_P2] = ~(d[0] ^ d[2] ^ d[3]);
        c[IX_P3] = ~(d[1] ^ d[2] ^ d[3]);
        return c;
    endfunction

    function automatic syn_t ham_syndrome(input cw_t c);
        syn_t s;
        s[0] = ~(c[IX_P1] ^ c[IX_D1] ^ c[IX_D2] ^ c[IX_D3]);
        s[1] = ~(c[IX_P2] ^ c[IX_D1] ^ c[IX_D3] ^ c[IX_D4]);
        s[2] = ~(c[IX_P3] ^ c[IX_D2] ^ c[IX_D3] ^ c[IX_D4]);
        return s;
    endfunction

    // syndrome value -> one-hot flip mask over the codeword
    function automatic cw_t ham_flip_mask(input syn_t s);
        cw_t m;
        m = '0;
        case (s)
            3'd1: m[IX_P1] = 1'b1;
            3'd2: m[IX_P2] = 1'b1;
            3'd3: m[IX_D1] = 1'b1;
            3'd4: m[IX_P3] = 1'b1;
            3'd5: m[IX_D2] = 1'b1;
            3'd6: m[IX_D4] = 1'b1;
            3'd7: m[IX_D3] = 1'b1;
            default: m = '0;
        endcase
        return m;
    endfunction

    function automatic nib_t ham_data_of(input cw_t c);
        return {c[IX_D4], c[IX_D3], c[IX_D2], c[IX_D1]};
    endfunction

endpackage

// File: rtl/ham_encoder.sv
module ham_encoder
    import ham74_pkg::*;
(
    input  nib_t data_i,
    output cw_t  code_o
);
    assign code_o = ham_encode(data_i);

    always_comb begin
        AST_ODD_GROUPS: assert (
            (code_o[IX_P1] ^ code_o[IX_D1] ^ code_o[IX_D2] ^ code_o[IX_D3]) &&
            (code_o[IX_P2] ^ code_o[IX_D1] ^ code_o[IX_D3] ^ code_o[IX_D4]) &&
            (code_o[IX_P3] ^ code_o[IX_D2] ^ code_o[IX_D3] ^ code_o[IX_D4])); // R2
        AST_DATA_PLACED: assert (ham_data_of(code_o) == data_i); // R1
    end
endmodule

// File: rtl/ham_corrector.sv
module ham_corrector
    import ham74_pkg::*;
(
    input  cw_t      code_i,
    output chk_res_t res_o
);
    syn_t syn;
    cw_t  mask;
    cw_t  fixed;

    always_comb begin
        syn   = ham_syndrome(code_i);
        mask  = ham_flip_mask(syn);
        fixed = code_i ^ mask;
        res_o.data = ham_data_of(fixed);
        res_o.syn  = syn;
        res_o.err  = (syn != '0);
    end

    always_comb begin
        if (res_o.syn == '0)
            AST_CLEAN_PASS: assert (res_o.data == ham_data_of(code_i)); // R4
        if (res_o.syn == 3'd1 || res_o.syn == 3'd2 || res_o.syn == 3'd4)
            AST_PARITY_HIT_KEEPS_DATA: assert (res_o.data == ham_data_of(code_i)); // R5
        AST_ONE_FLIP_PER_ERROR: assert ($countones(code_i ^ fixed) == (res_o.err ? 1 : 0)); // R6
        if (res_o.err)
            AST_REPAIR_IS_CLEAN: assert (ham_syndrome(fixed) == '0); // R7
    end
endmodule

// File: rtl/ham_out_stage.sv
module ham_out_stage #(
    parameter int W   = 8,
    parameter bit REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    generate
        if (REG) begin : g_reg
            logic [W-1:0] q_r;
            always_ff @(posedge clk) begin
                if (rst) q_r <= '0;
                else     q_r <= d_i;
            end
            assign q_o = q_r;
        end else begin : g_pass
            assign q_o = d_i;
        end
    endgenerate
endmodule

// File: rtl/ham74_odd_codec.sv
module ham74_odd_codec
    import ham74_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] enc_data_in,
    output logic [CODE_W-1:0] enc_code_out,
    input  logic [CODE_W-1:0] dec_code_in,
    output logic [DATA_W-1:0] dec_data_out,
    output logic [SYN_W-1:0]  dec_syndrome,
    output logic              dec_error
);
    localparam int RES_W = $bits(chk_res_t);

    cw_t      enc_comb;
    chk_res_t chk_comb;
    chk_res_t chk_q;

    ham_encoder u_enc (
        .data_i (enc_data_in),
        .code_o (enc_comb)
    );

    ham_corrector u_cor (
        .code_i (dec_code_in),
        .res_o  (chk_comb)
    );

    ham_out_stage #(.W(CODE_W), .REG(OUT_REG)) u_enc_stage (
        .clk (clk),
        .rst (rst),
        .d_i (enc_comb),
        .q_o (enc_code_out)
    );

    ham_out_stage #(.W(RES_W), .REG(OUT_REG)) u_chk_stage (
        .clk (clk),
        .rst (rst),
        .d_i (chk_comb),
        .q_o (chk_q)
    );

    assign dec_data_out = chk_q.data;
    assign dec_syndrome = chk_q.syn;
    assign dec_error    = chk_q.err;

    AST_FLAG_TRACKS_SYN: assert property (@(posedge clk) disable iff (rst)
        dec_error == (dec_syndrome != '0)); // R6

    generate
        if (OUT_REG) begin : g_lat_chk
            AST_ENC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> enc_code_out == ham_encode($past(enc_data_in))); // R8
            AST_SYN_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> dec_syndrome == ham_syndrome($past(dec_code_in))); // R8
        end
    endgenerate
endmodule

// File: tb/tb_ham74_odd_codec.sv
module tb_ham74_odd_codec;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] enc_data_in = '0;
    logic [6:0] enc_code_out;
    logic [6:0] dec_code_in = '0;
    logic [3:0] dec_data_out;
    logic [2:0] dec_syndrome;
    logic       dec_error;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ham74_odd_codec dut (
        .clk          (clk),
        .rst          (rst),
        .enc_data_in  (enc_data_in),
        .enc_code_out (enc_code_out),
        .dec_code_in  (dec_code_in),
        .dec_data_out (dec_data_out),
        .dec_syndrome (dec_syndrome),
        .dec_error    (dec_error)
    );

    // bench model: odd parity by counting ones in each group
    function automatic logic [6:0] exp_code(input logic [3:0] d);
        int c1, c2, c3;
        logic [6:0] w;
        c1 = int'(d[0]) + int'(d[1]) + int'(d[2]);
        c2 = int'(d[0]) + int'(d[2]) + int'(d[3]);
        c3 = int'(d[1]) + int'(d[2]) + int'(d[3]);
        w[0] = (c1 % 2 == 0);
        w[1] = (c2 % 2 == 0);
        w[2] = d[0];
        w[3] = (c3 % 2 == 0);
        w[4] = d[1];
        w[5] = d[2];
        w[6] = d[3];
        return w;
    endfunction

    function automatic logic [2:0] exp_syn(input int pos);
        case (pos)
            0: return 3'd1;
            1: return 3'd2;
            2: return 3'd3;
            3: return 3'd4;
            4: return 3'd5;
            5: return 3'd7;
            6: return 3'd6;
            default: return 3'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // pos 0..6 flips that codeword index, 7 means clean
    task automatic run_case(input logic [3:0] d, input int pos);
        logic [6:0] cw;
        logic [3:0] want;
        cw = exp_code(d);
        if (pos < 7) cw[pos] = ~cw[pos];
        want = (pos == 0 || pos == 1 || pos == 3) ? {cw[6], cw[5], cw[4], cw[2]} : d;
        @(negedge clk);
        enc_data_in = d;
        dec_code_in = cw;
        @(negedge clk);
        chk("R1 codeword", 32'(enc_code_out), 32'(exp_code(d)));
        chk("R2 odd groups", 32'({enc_code_out[0]^enc_code_out[2]^enc_code_out[4]^enc_code_out[5],
                                  enc_code_out[1]^enc_code_out[2]^enc_code_out[5]^enc_code_out[6],
                                  enc_code_out[3]^enc_code_out[4]^enc_code_out[5]^enc_code_out[6]}), 32'h7);
        if (pos == 0 || pos == 1 || pos == 3)
            chk("R5 parity flip data", 32'(dec_data_out), 32'(want));
        else
            chk("R4 data recovered", 32'(dec_data_out), 32'(want));
        if (pos == 7) chk("R3 clean syndrome", 32'(dec_syndrome), 32'h0);
        else          chk("R7 syndrome map", 32'(dec_syndrome), 32'(exp_syn(pos)));
        chk("R6 error flag", 32'(dec_error), 32'(pos != 7));
    endtask

    initial begin : watchdog
        #2000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        repeat (2) @(negedge clk);
        enc_data_in = 4'hF;
        dec_code_in = 7'h55;
        @(negedge clk);
        chk("R8 reset enc", 32'(enc_code_out), 32'h0);
        chk("R8 reset data", 32'(dec_data_out), 32'h0);
        chk("R8 reset syn", 32'(dec_syndrome), 32'h0);
        chk("R8 reset err", 32'(dec_error), 32'h0);
        rst = 1'b0;

        // exhaustive: every nibble, every single flip, and clean
        for (int d = 0; d < 16; d++)
            for (int p = 0; p < 8; p++)
                run_case(4'(d), p);

        // directed corners
        run_case(4'h0, 7);
        run_case(4'hF, 5);
        run_case(4'hF, 6);

        // R8: output holds until the next rising edge, then updates
        run_case(4'h3, 7);
        @(negedge clk);
        enc_data_in = 4'hC;
        dec_code_in = exp_code(4'hC) ^ 7'h04;
        #1;
        chk("R8 hold before edge", 32'(enc_code_out), 32'(exp_code(4'h3)));
        chk("R8 hold syn before edge", 32'(dec_syndrome), 32'h0);
        @(negedge clk);
        chk("R8 enc after edge", 32'(enc_code_out), 32'(exp_code(4'hC)));
        chk("R8 data after edge", 32'(dec_data_out), 32'hC);
        chk("R8 syn after edge", 32'(dec_syndrome), 32'h3);

        // seeded random mix
        for (int i = 0; i < 300; i++)
            run_case(4'($urandom_range(15)), int'($urandom_range(7)));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule